// File: doc/BRIEF.md
# Third-Order Cascaded Noise-Shaping Fraction Modulator

This block turns a static fractional frequency word into a stream of integer division ratios for a fractional-N feedback divider. Three first-order accumulator stages are chained: the first integrates the fraction, and each later stage integrates the residue the stage before it left behind. The overflow bits of the three stages are merged by a small difference network. The merge pushes the quantisation error towards high frequencies, and the long-run average of the emitted ratio equals the integer base plus the fraction.

A free-running pseudo-random bit can be fed into the carry input of the last stage. This breaks up the short repeating patterns that a rational fraction would otherwise produce. Because of the difference network, the dither reaches the output only as high-pass shaped noise. The block is clocked by the divided reference, so it produces one new ratio per reference period.

Top module: `dsm_mash111`

## Requirements
- R1: While `rst` is high at a rising edge, all three stage residues, all carry delay registers and `div_o` are cleared to 0. The pseudo-random register is loaded with the value 1. On the first edge after reset, the offset is never negative.
- R2: `div_o` is registered. The value present after rising edge k is computed from `frac_i`, `int_i` and `dither_en_i` as sampled at edge k and from the state held before that edge.
- R3: At every edge, stage 1 adds `frac_i` to its residue modulo 2^FRAC_W and produces carry c1 on overflow. Stage 2 adds the updated stage-1 residue to its own residue and produces c2. Stage 3 adds the updated stage-2 residue plus the dither bit to its residue and produces c3. When a carry is 1, the new residue is not larger than the value added; otherwise it is not smaller.
- R4: The offset is c1 + c2 − c2' + c3 − 2·c3' + c3'', where ' marks the value from one edge earlier and '' from two edges earlier. `div_o` = `int_i` + offset, and the offset always lies in −3..+4.
- R5: When `dither_en_i` is high, the dither bit is the most significant bit of the pseudo-random register. When it is low, the dither bit is 0 and the register state has no effect on `div_o`.
- R6: The pseudo-random register is 23 bits wide and shifts at every edge outside reset, whatever `dither_en_i` is. The next state is {state[21:0], state[22] XOR state[17]} (polynomial x^23 + x^18 + 1), and the state never becomes zero.
- R7: With `frac_i` = F held constant over 4096 edges, the sum of (`div_o` − `int_i`) lies within 8 of 4096·F/65536, with or without dither.
- R8: With `frac_i` = 0 and dither disabled since reset, `div_o` equals `int_i` on every cycle.
- R9: `div_o` is INT_W+1 bits wide, so `int_i` + 4 does not wrap. `int_i` must be at least 3 so that the ratio stays non-negative.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Divided reference clock |
| rst | input | 1 | Synchronous active-high reset |
| frac_i | input | FRAC_W | Fractional word, weight 2^-FRAC_W per LSB |
| int_i | input | INT_W | Integer base of the division ratio |
| dither_en_i | input | 1 | Feeds the pseudo-random bit into stage 3 |
| div_o | output | INT_W+1 | Instantaneous division ratio |

## Verification
The hardest behaviour to reach from the ports is a stage-3 overflow that coincides with non-zero carry history. At that point all six terms of the difference network act at once, and the dither bit decides the outcome. A single-bit carry-in into a 16-bit accumulator seldom changes anything on its own. The stimulus therefore holds large, odd fractions (including values near 0x8000 and 0xFFFF) for long runs with dither both on and off, so that stage 3 wraps often while stage 2 carries. A behavioural integer model then checks every cycle.

// File: rtl/dsm_pkg.sv
package dsm_pkg;
  // number of cascaded first-order stages (fixed third-order structure)
  localparam int NSTG  = 3;
  // offset spans -3..+4, needs 4 signed bits
  localparam int OFS_W = 4;
  typedef logic signed [OFS_W-1:0] ofs_t;
endpackage

// File: rtl/dsm_lfsr.sv
module dsm_lfsr #(
  parameter int LEN    = 23,
  parameter int FB_TAP = 18
) (
  input  logic clk,
  input  logic rst,
  output logic bit_o
);
  logic [LEN-1:0] st_q;

  always_ff @(posedge clk) begin
    if (rst) st_q <= {{(LEN-1){1'b0}}, 1'b1};
    else     st_q <= {st_q[LEN-2:0], st_q[LEN-1] ^ st_q[FB_TAP-1]};
  end

  assign bit_o = st_q[LEN-1];

  // R6: a maximal sequence never reaches the all-zero lock-up state
  p_lfsr_live_r6: assert property (@(posedge clk) disable iff (rst)
    st_q != '0);
endmodule

// File: rtl/dsm_accum.sv
module dsm_accum #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] add_i,
  input  logic         cin_i,
  output logic [W-1:0] nxt_o,
  output logic         carry_o
);
  logic [W-1:0] res_q;
  logic [W:0]   sum_w;

  assign sum_w   = {1'b0, res_q} + {1'b0, add_i} + {{W{1'b0}}, cin_i};
  assign nxt_o   = sum_w[W-1:0];
  assign carry_o = sum_w[W];

  always_ff @(posedge clk) begin
    if (rst) res_q <= '0;
    else     res_q <= nxt_o;
  end

  // R3: overflow leaves a residue no larger than the addend
  p_carry_wrap_r3: assert property (@(posedge clk) disable iff (rst)
    carry_o |-> (nxt_o <= add_i));
  // R3: without overflow the residue is at least the addend
  p_no_wrap_r3: assert property (@(posedge clk) disable iff (rst)
    !carry_o |-> (nxt_o >= add_i));
endmodule

// File: rtl/dsm_cancel.sv
module dsm_cancel
  import dsm_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic [NSTG-1:0] cy_i,
  output ofs_t            ofs_o
);
  logic c2_d1_q, c3_d1_q, c3_d2_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      c2_d1_q <= 1'b0;
      c3_d1_q <= 1'b0;
      c3_d2_q <= 1'b0;
    end else begin
      c2_d1_q <= cy_i[1];
      c3_d1_q <= cy_i[2];
      c3_d2_q <= c3_d1_q;
    end
  end

  // first difference of c2, second difference of c3, plus c1
  always_comb begin
    ofs_o = ofs_t'({3'b000, cy_i[0]})
          + ofs_t'({3'b000, cy_i[1]}) - ofs_t'({3'b000, c2_d1_q})
          + ofs_t'({3'b000, cy_i[2]}) - ofs_t'({2'b00, c3_d1_q, 1'b0})
          + ofs_t'({3'b000, c3_d2_q});
  end

  // R1: cleared history means no negative terms on the first edge
  p_first_ofs_nonneg_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (ofs_o >= 0));
endmodule

// File: rtl/dsm_mash111.sv
module dsm_mash111
  import dsm_pkg::*;
#(
  parameter int FRAC_W = 16,
  parameter int INT_W  = 8,
  parameter int LFSR_W = 23,
  parameter int LFSR_T = 18
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [FRAC_W-1:0] frac_i,
  input  logic [INT_W-1:0]  int_i,
  input  logic              dither_en_i,
  output logic [INT_W:0]    div_o
);
  localparam int SUM_W = INT_W + 2;

  logic              dith_raw_w, dith_w;
  logic [FRAC_W-1:0] nxt_w [NSTG];
  logic [NSTG-1:0]   cy_w;
  ofs_t              ofs_w;
  logic signed [SUM_W-1:0] ratio_w;

  dsm_lfsr #(.LEN(LFSR_W), .FB_TAP(LFSR_T)) u_lfsr (
    .clk(clk), .rst(rst), .bit_o(dith_raw_w));

  assign dith_w = dither_en_i & dith_raw_w;

  for (genvar k = 0; k < NSTG; k++) begin : g_stg
    logic [FRAC_W-1:0] add_w;
    logic              cin_w;
    if (k == 0) begin : g_first
      assign add_w = frac_i;
    end else begin : g_chain
      assign add_w = nxt_w[k-1];
    end
    if (k == NSTG-1) begin : g_dith
      assign cin_w = dith_w;
    end else begin : g_nodith
      assign cin_w = 1'b0;
    end
    dsm_accum #(.W(FRAC_W)) u_acc (
      .clk(clk), .rst(rst), .add_i(add_w), .cin_i(cin_w),
      .nxt_o(nxt_w[k]), .carry_o(cy_w[k]));
  end

  dsm_cancel u_cancel (.clk(clk), .rst(rst), .cy_i(cy_w), .ofs_o(ofs_w));

  assign ratio_w = $signed({2'b00, int_i}) + $signed({{(SUM_W-OFS_W){ofs_w[OFS_W-1]}}, ofs_w});

  always_ff @(posedge clk) begin
    if (rst) div_o <= '0;
    else     div_o <= ratio_w[INT_W:0];
  end

  // R1: the ratio register leaves reset at zero
  p_reset_zero_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (div_o == '0));
  // R4: the emitted ratio stays within -3..+4 of the sampled base
  p_ratio_window_r4: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && ($past(int_i) >= 3)) |->
      ((int'(div_o) - int'($past(int_i)) >= -3) &&
       (int'(div_o) - int'($past(int_i)) <= 4)));
endmodule

// File: tb/dsm_mash111_tb_top.sv
module dsm_mash111_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] frac = '0;
  logic [7:0]  base = 8'd40;
  logic        den = 1'b0;
  logic [8:0]  div_o;

  int tests = 0, fails = 0, cyc = 0;
  bit armed = 0, done = 0;

  always #5 clk = ~clk;

  dsm_mash111 dut_i (.clk(clk), .rst(rst), .frac_i(frac), .int_i(base),
                     .dither_en_i(den), .div_o(div_o));

  // behavioural reference
  int e1, e2, e3, c2p, c3p, c3pp, expv;
  logic [22:0] prn;
  always @(posedge clk) begin
    int d, c1, c2, c3, s;
    if (rst) begin
      e1 = 0; e2 = 0; e3 = 0; c2p = 0; c3p = 0; c3pp = 0; expv = 0;
      prn = 23'd1;
    end else begin
      d = den ? int'(prn[22]) : 0;
      s = e1 + int'(frac); c1 = s / 65536; e1 = s % 65536;
      s = e2 + e1;         c2 = s / 65536; e2 = s % 65536;
      s = e3 + e2 + d;     c3 = s / 65536; e3 = s % 65536;
      expv = int'(base) + c1 + c2 - c2p + c3 - 2 * c3p + c3pp;
      c3pp = c3p; c3p = c3; c2p = c2;
      prn = {prn[21:0], prn[22] ^ prn[17]};
    end
    armed = 1;
  end

  // R2 R3 R4 R5 R6: cycle-exact compare against the model
  always @(negedge clk) begin
    if (armed && !done) begin
      tests++;
      if (int'(div_o) != expv) begin
        fails++;
        $display("FAIL R2/R3/R4/R5/R6 cycle %0d: div_o=%0d expected %0d", cyc, div_o, expv);
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog: run did not finish, actual cycle %0d expected < 150000", cyc);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic do_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    tests++;
    if (div_o != 0) begin
      fails++;
      $display("FAIL R1: div_o=%0d during reset expected 0", div_o);
    end
    rst = 1'b0;
  endtask

  task automatic mean_check(input int f, input bit dith);
    int acc = 0;
    long_ok: begin end
    do_reset();
    frac = f[15:0]; den = dith; base = 8'd40;
    repeat (8) @(negedge clk);
    for (int i = 0; i < 4096; i++) begin
      @(negedge clk);
      acc += int'(div_o) - 40;
    end
    tests++;
    if ((acc * 65536 - 4096 * f) > 8 * 65536 || (4096 * f - acc * 65536) > 8 * 65536) begin
      fails++;
      $display("FAIL R7: offset sum=%0d expected %0d/16 (+-8), F=%0h", acc, f, f);
    end
  endtask

  initial begin
    // R1 R8: zero fraction without dither yields the bare base
    do_reset();
    frac = 16'h0000; den = 1'b0; base = 8'd57;
    @(negedge clk);
    for (int i = 0; i < 64; i++) begin
      @(negedge clk);
      tests++;
      if (div_o != 9'd57) begin
        fails++;
        $display("FAIL R8: div_o=%0d expected 57", div_o);
      end
    end
    // R9: largest base plus positive offset must not wrap
    do_reset();
    base = 8'd255; frac = 16'hFFFF; den = 1'b1;
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      tests++;
      if (div_o < 9'd252) begin
        fails++;
        $display("FAIL R9: div_o=%0d expected >= 252", div_o);
      end
    end
    // R2: a base change shows up one edge later
    base = 8'd10; frac = 16'h0000; den = 1'b0;
    do_reset();
    repeat (4) @(negedge clk);
    base = 8'd90;
    @(negedge clk);
    tests++;
    if (div_o != 9'd90) begin
      fails++;
      $display("FAIL R2: div_o=%0d expected 90", div_o);
    end
    // R7: long-run mean for several fractions
    mean_check(16'h4000, 1'b0);
    mean_check(16'h4000, 1'b1);
    mean_check(16'h1235, 1'b1);
    mean_check(16'hC001, 1'b0);
    // R3 R5: stress stage-3 wraps with large odd fractions
    do_reset();
    for (int blk = 0; blk < 40; blk++) begin
      case (blk % 4)
        0: frac = 16'h8001;
        1: frac = 16'hFFFF;
        2: frac = 16'h7FFF;
        default: frac = 16'($urandom);
      endcase
      base = 8'(3 + ($urandom % 250));
      den = blk[1];
      repeat (400) @(negedge clk);
    end
    @(negedge clk);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule